// File: doc/BRIEF.md
# Vector Word Equality Compare Unit

This block executes one SIMD integer instruction: it compares two 128-bit vectors as four independent 32-bit lanes and writes back a per-lane mask. Each lane of the mask is all ones where the two source words match and all zeros where they differ. The unit holds its own 32-entry by 128-bit vector register file. A preload port fills that file, and a read port brings any entry out. An instruction arrives as a 32-bit word with a valid strobe. The unit decodes the target and source register numbers and the record bit from fixed fields of that word.

When the record bit is set, the unit folds the four lane results into two summary flags. The all-true flag is set when every lane matched, and the all-false flag is set when no lane matched. Both flags go into a 4-bit field of a 32-bit condition register. The other seven fields of that register are never touched. A vector-enable input gates the whole operation. With vector execution disabled, a recognised instruction changes nothing and raises a one-cycle trap pulse instead.

Top module: `vweq_unit`

## Requirements
- R1: For each lane i (bits 32*i+31 down to 32*i), the word written to the target register is 32'hFFFF_FFFF when source A and source B hold the same word in that lane, and 32'h0000_0000 otherwise.
- R2: With the record bit set, cond_o[7] becomes 1 exactly when all four lanes are equal, and cond_o[6] becomes 0.
- R3: With the record bit set, cond_o[5] becomes 1 exactly when no lane is equal, and cond_o[4] becomes 0. The two flags are therefore never both 1.
- R4: With the record bit clear (insn_word[10] = 0), the mask is still written, but cond_o does not change.
- R5: A recognised instruction with vec_enable = 0 writes no register and leaves cond_o unchanged. It raises trap_o for one cycle, visible after the second rising edge counted from the accepting edge, and done_o stays low.
- R6: An instruction is recognised only when insn_word[31:26] = 6'd4 and insn_word[9:0] = 10'd134. Any other word leaves the register file and cond_o unchanged and raises neither done_o nor trap_o.
- R7: The target register number is insn_word[25:21], source A is insn_word[20:16], source B is insn_word[15:11], and the record bit is insn_word[10].
- R8: A recognised instruction with vec_enable = 1, sampled at rising edge k, updates the target register and cond_o at edge k+1. done_o is high for exactly the cycle that follows edge k+1.
- R9: Sources are read at the accepting edge, so a target that is also a source is compared using its old contents.
- R10: Bits 31:8 and 3:0 of cond_o never change after reset.
- R11: During and after reset, done_o and trap_o are 0, cond_o equals the parameter CR_INIT (default 32'h9C3A_E561), and every register-file entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| vec_enable | input | 1 | Vector execution enabled |
| pl_we | input | 1 | Register-file preload write enable |
| pl_addr | input | 5 | Preload register number |
| pl_data | input | 128 | Preload data |
| rd_addr | input | 5 | Read-port register number |
| rd_data | output | 128 | Read-port data (combinational) |
| cond_o | output | 32 | Condition register, field with flags at bits 7:4 |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | One-cycle vector-unavailable pulse |

## Verification
An instruction accepted at edge k shows all of its effects after edge k+1. These are the mask in the register file, the new condition field, and the done or trap pulse. So the bench samples them at the falling edge that follows k+1. The bench's behavioural model applies each pending result one edge after capture and compares done, trap and the full condition register at every falling edge. Register contents are read back through the read port once an instruction has finished. Instructions are spaced at least three cycles apart, so every result is checked before the next one can overlap it.

// File: rtl/vweq_pkg.sv
package vweq_pkg;

    localparam int LANES    = 4;
    localparam int LANE_W   = 32;
    localparam int VEC_W    = LANES * LANE_W;
    localparam int NREG     = 32;
    localparam int RA_W     = $clog2(NREG);
    localparam int CR_W     = 32;
    localparam int FLD_W    = 4;
    localparam int CR_FIELD = 6;

    localparam logic [5:0] PRI_OP = 6'd4;
    localparam logic [9:0] EXT_OP = 10'd134;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [RA_W-1:0]  ridx_t;

    typedef struct packed {
        logic  hit;
        ridx_t vt;
        ridx_t va;
        ridx_t vb;
        logic  rc;
    } dec_t;

    typedef struct packed {
        logic all_true;
        logic all_false;
    } summ_t;

    typedef struct packed {
        logic  exec;
        logic  trap;
        ridx_t vt;
        logic  rc;
        vec_t  mask;
        summ_t summ;
    } stage_t;

    // Bit positions: primary opcode [31:26], target [25:21],
    // source A [20:16], source B [15:11], record [10], extended [9:0].
    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d.hit = (w[31:26] == PRI_OP) && (w[9:0] == EXT_OP);
        d.vt  = w[25:21];
        d.va  = w[20:16];
        d.vb  = w[15:11];
        d.rc  = w[10];
        return d;
    endfunction

    function automatic logic [FLD_W-1:0] fold_summary(input summ_t s);
        return {s.all_true, 1'b0, s.all_false, 1'b0};
    endfunction

    // LSB position of a field counted from the most significant end.
    function automatic int field_lsb(input int fld);
        return (CR_W / FLD_W - 1 - fld) * FLD_W;
    endfunction

endpackage

// File: rtl/vweq_decode.sv
module vweq_decode
    import vweq_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    always_comb begin
        dec = decode_word(word);
    end

endmodule

// File: rtl/vweq_lanecmp.sv
module vweq_lanecmp
    import vweq_pkg::*;
#(
    parameter int N_LANE = LANES,
    parameter int W_LANE = LANE_W,
    localparam int W_VEC = N_LANE * W_LANE
) (
    input  logic [W_VEC-1:0] src_a,
    input  logic [W_VEC-1:0] src_b,
    output logic [W_VEC-1:0] mask,
    output summ_t            summ
);

    logic [N_LANE-1:0] eq;

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        assign eq[i] = (src_a[i*W_LANE +: W_LANE] == src_b[i*W_LANE +: W_LANE]);
        assign mask[i*W_LANE +: W_LANE] = {W_LANE{eq[i]}};
    end

    always_comb begin
        summ.all_true  = &eq;
        summ.all_false = ~|eq;
    end

endmodule

// File: rtl/vweq_regfile.sv
module vweq_regfile
    import vweq_pkg::*;
#(
    parameter int DEPTH = NREG,
    parameter int WIDTH = VEC_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pl_we,
    input  logic [AW-1:0]    pl_addr,
    input  logic [WIDTH-1:0] pl_data,
    input  logic             wb_we,
    input  logic [AW-1:0]    wb_addr,
    input  logic [WIDTH-1:0] wb_data,
    input  logic [AW-1:0]    ra_addr,
    output logic [WIDTH-1:0] ra_data,
    input  logic [AW-1:0]    rb_addr,
    output logic [WIDTH-1:0] rb_data,
    input  logic [AW-1:0]    rx_addr,
    output logic [WIDTH-1:0] rx_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (pl_we) begin
            mem[pl_addr] <= pl_data;
        end else if (wb_we) begin
            mem[wb_addr] <= wb_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign rx_data = mem[rx_addr];

endmodule

// File: rtl/vweq_crfile.sv
module vweq_crfile
    import vweq_pkg::*;
#(
    parameter int            WIDTH = CR_W,
    parameter int            FIELD = CR_FIELD,
    parameter logic [WIDTH-1:0] INIT = '0,
    localparam int           LSB   = field_lsb(FIELD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [FLD_W-1:0] fld_val,
    output logic [WIDTH-1:0] cond
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond <= INIT;
        end else if (upd) begin
            cond[LSB +: FLD_W] <= fld_val;
        end
    end

endmodule

// File: rtl/vweq_unit.sv
module vweq_unit
    import vweq_pkg::*;
#(
    parameter logic [CR_W-1:0] CR_INIT = 32'h9C3A_E561
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic              vec_enable,
    input  logic              pl_we,
    input  logic [RA_W-1:0]   pl_addr,
    input  logic [VEC_W-1:0]  pl_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [VEC_W-1:0]  rd_data,
    output logic [CR_W-1:0]   cond_o,
    output logic              done_o,
    output logic              trap_o
);

    dec_t   dec;
    vec_t   opa;
    vec_t   opb;
    vec_t   mask;
    summ_t  summ;
    stage_t st;
    logic   accept;

    vweq_decode u_dec (
        .word (insn_word),
        .dec  (dec)
    );

    vweq_regfile #(.DEPTH(NREG), .WIDTH(VEC_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .pl_we   (pl_we),
        .pl_addr (pl_addr),
        .pl_data (pl_data),
        .wb_we   (st.exec),
        .wb_addr (st.vt),
        .wb_data (st.mask),
        .ra_addr (dec.va),
        .ra_data (opa),
        .rb_addr (dec.vb),
        .rb_data (opb),
        .rx_addr (rd_addr),
        .rx_data (rd_data)
    );

    vweq_lanecmp #(.N_LANE(LANES), .W_LANE(LANE_W)) u_cmp (
        .src_a (opa),
        .src_b (opb),
        .mask  (mask),
        .summ  (summ)
    );

    assign accept = insn_valid && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            done_o <= 1'b0;
            trap_o <= 1'b0;
        end else begin
            st.exec <= accept && vec_enable;
            st.trap <= accept && !vec_enable;
            st.vt   <= dec.vt;
            st.rc   <= dec.rc;
            st.mask <= mask;
            st.summ <= summ;
            done_o  <= st.exec;
            trap_o  <= st.trap;
        end
    end

    vweq_crfile #(.WIDTH(CR_W), .FIELD(CR_FIELD), .INIT(CR_INIT)) u_cr (
        .clk     (clk),
        .rst     (rst),
        .upd     (st.exec && st.rc),
        .fld_val (fold_summary(st.summ)),
        .cond    (cond_o)
    );

endmodule

// File: rtl/vweq_chk.sv
module vweq_chk (
    input logic        clk,
    input logic        rst,
    input logic        insn_valid,
    input logic [31:0] insn_word,
    input logic        vec_enable,
    input logic [31:0] cond_o,
    input logic        done_o,
    input logic        trap_o
);

    logic known;
    assign known = (insn_word[31:26] == 6'd4) && (insn_word[9:0] == 10'd134);

    // R8
    done_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && known && vec_enable) |-> ##2 (done_o && !trap_o));

    // R5
    trap_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && known && !vec_enable) |-> ##2 (trap_o && !done_o));

    // R6
    unknown_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !known) |-> ##2 (!trap_o && !done_o));

    // R4
    norecord_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && known && !insn_word[10]) |-> ##2 $stable(cond_o));

    // R10
    other_fields_chk: assert property (@(posedge clk) disable iff (rst)
        $stable({cond_o[31:8], cond_o[3:0]}));

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cond_o[7] && cond_o[5]));

    // R5
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, trap_o}));

endmodule

bind vweq_unit vweq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .vec_enable (vec_enable),
    .cond_o     (cond_o),
    .done_o     (done_o),
    .trap_o     (trap_o)
);

// File: tb/vweq_unit_tb.sv
module vweq_unit_tb;

    localparam logic [31:0] INIT = 32'h9C3A_E561;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn_word = '0;
    logic         vec_enable = 1'b1;
    logic         pl_we = 1'b0;
    logic [4:0]   pl_addr = '0;
    logic [127:0] pl_data = '0;
    logic [4:0]   rd_addr = '0;
    logic [127:0] rd_data;
    logic [31:0]  cond_o;
    logic         done_o;
    logic         trap_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vweq_unit #(.CR_INIT(INIT)) u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .vec_enable(vec_enable), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cond_o(cond_o),
        .done_o(done_o), .trap_o(trap_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [127:0] ref_rf [32];
    logic [31:0]  ref_cond;
    bit           exp_done, exp_trap;
    bit           p_do, p_trap, p_rc, p_at, p_af;
    logic [4:0]   p_vt;
    logic [127:0] p_mask;

    always @(posedge clk) begin
        bit n_do, n_trap, at, af;
        logic [127:0] m, a, b;
        if (rst) begin
            foreach (ref_rf[i]) ref_rf[i] = '0;
            ref_cond = INIT;
            exp_done = 0; exp_trap = 0; p_do = 0; p_trap = 0;
        end else begin
            n_do = 0; n_trap = 0; at = 1; af = 1; m = '0;
            if (insn_valid && insn_word[31:26] == 6'd4 && insn_word[9:0] == 10'd134) begin
                if (vec_enable) begin
                    a = ref_rf[insn_word[20:16]];
                    b = ref_rf[insn_word[15:11]];
                    for (int i = 0; i < 4; i++) begin
                        if (a[i*32 +: 32] == b[i*32 +: 32]) begin
                            m[i*32 +: 32] = 32'hFFFF_FFFF; af = 0;
                        end else begin
                            at = 0;
                        end
                    end
                    n_do = 1;
                end else begin
                    n_trap = 1;
                end
            end
            exp_done = p_do;
            exp_trap = p_trap;
            if (p_do) begin
                ref_rf[p_vt] = p_mask;
                if (p_rc) ref_cond[7:4] = {p_at, 1'b0, p_af, 1'b0};
            end
            if (pl_we) ref_rf[pl_addr] = pl_data;
            p_do = n_do; p_trap = n_trap; p_mask = m; p_at = at; p_af = af;
            p_vt = insn_word[25:21]; p_rc = insn_word[10];
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks += 3;
            if (done_o !== exp_done) begin
                errors++; $display("FAIL R8 done_o act=%0b exp=%0b", done_o, exp_done);
            end
            if (trap_o !== exp_trap) begin
                errors++; $display("FAIL R5 trap_o act=%0b exp=%0b", trap_o, exp_trap);
            end
            if (cond_o !== ref_cond) begin
                errors++; $display("FAIL R10 cond_o act=%h exp=%h", cond_o, ref_cond);
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] mk(input logic [4:0] t, input logic [4:0] a,
                                       input logic [4:0] b, input bit rc);
        return {6'd4, t, a, b, rc, 10'd134};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [4:0] a, input logic [127:0] d);
        @(negedge clk);
        pl_we = 1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 0;
    endtask

    bit seen_done, seen_trap;

    task automatic issue(input logic [31:0] w, input bit en);
        @(negedge clk);
        insn_valid = 1; insn_word = w; vec_enable = en;
        @(negedge clk);
        insn_valid = 0;
        @(negedge clk);
        seen_done = done_o; seen_trap = trap_o;
        @(negedge clk);
        vec_enable = 1;
    endtask

    task automatic peek(input logic [4:0] a, output logic [127:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    localparam logic [127:0] V2  = 128'h1111_1111_2222_2222_3333_3333_4444_4444;
    localparam logic [127:0] V4  = 128'h5555_5555_6666_6666_7777_7777_8888_8888;
    localparam logic [127:0] V6  = 128'h1111_1111_DEAD_BEEF_3333_3333_0000_0001;
    localparam logic [127:0] V10 = 128'hABCD_0123_4567_89AB_CDEF_0011_2233_4455;
    localparam logic [127:0] ONES = {128{1'b1}};

    initial begin
        logic [127:0] d;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 cond reset", {96'd0, cond_o}, {96'd0, INIT});
        check("R11 done/trap reset", {126'd0, done_o, trap_o}, 128'd0);
        rst = 0;
        @(negedge clk);
        peek(5'd9, d);
        check("R11 rf reset", d, '0);

        preload(5'd2, V2);
        preload(5'd3, V2);
        preload(5'd4, V4);
        preload(5'd6, V6);
        preload(5'd10, V10);

        // R1 R2 all equal
        issue(mk(5'd1, 5'd2, 5'd3, 1), 1);
        check("R8 done pulse", {127'd0, seen_done}, 128'd1);
        peek(5'd1, d);
        check("R1 all-equal mask", d, ONES);
        check("R2 field 1000", {124'd0, cond_o[7:4]}, 128'h8);

        // R3 all unequal
        issue(mk(5'd5, 5'd2, 5'd4, 1), 1);
        peek(5'd5, d);
        check("R3 unequal mask", d, '0);
        check("R3 field 0010", {124'd0, cond_o[7:4]}, 128'h2);

        // R1 mixed lanes
        issue(mk(5'd7, 5'd2, 5'd6, 1), 1);
        peek(5'd7, d);
        check("R1 mixed mask", d, 128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000);
        check("R2 mixed field 0000", {124'd0, cond_o[7:4]}, 128'h0);

        // R4 record clear
        issue(mk(5'd8, 5'd2, 5'd3, 0), 1);
        peek(5'd8, d);
        check("R4 mask still written", d, ONES);
        check("R4 field unchanged", {124'd0, cond_o[7:4]}, 128'h0);

        // R5 disabled vector
        issue(mk(5'd9, 5'd2, 5'd3, 1), 0);
        check("R5 trap seen", {126'd0, seen_trap, seen_done}, 128'h2);
        peek(5'd9, d);
        check("R5 target untouched", d, '0);
        check("R5 field unchanged", {124'd0, cond_o[7:4]}, 128'h0);

        // R6 unrecognised words
        issue({6'd4, 5'd11, 5'd2, 5'd3, 1'b1, 10'd135}, 1);
        check("R6 ext mismatch silent", {126'd0, seen_trap, seen_done}, 128'd0);
        issue({6'd5, 5'd11, 5'd2, 5'd3, 1'b1, 10'd134}, 0);
        check("R6 pri mismatch no trap", {126'd0, seen_trap, seen_done}, 128'd0);
        peek(5'd11, d);
        check("R6 rf untouched", d, '0);
        check("R6 field unchanged", {124'd0, cond_o[7:4]}, 128'h0);

        // R7 same register on both sources
        issue(mk(5'd12, 5'd10, 5'd10, 1), 1);
        peek(5'd12, d);
        check("R7 self compare mask", d, ONES);
        check("R7 field 1000", {124'd0, cond_o[7:4]}, 128'h8);

        // R9 target equals source A
        issue(mk(5'd2, 5'd2, 5'd4, 1), 1);
        peek(5'd2, d);
        check("R9 old source used", d, '0);
        check("R9 field 0010", {124'd0, cond_o[7:4]}, 128'h2);
        issue(mk(5'd13, 5'd2, 5'd5, 1), 1);
        peek(5'd13, d);
        check("R9 new value visible later", d, ONES);

        // R10 other fields
        check("R10 other fields", {104'd0, cond_o[31:8], cond_o[3:0]},
              {104'd0, INIT[31:8], INIT[3:0]});

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule